// File: doc/BRIEF.md
# Staged PLL Control Register File

This block is a byte-wide control register bank for a clock generator. A serial slave (out of scope) drives it through a plain parallel port: an 8-bit address, write data with a write strobe, and a read strobe with registered read data. The bank holds a fixed revision byte, a 12-bit feedback divide value split across two byte registers, a VCO band select with its derived post-divider, a charge-pump current code and a 5-bit sampling phase. Every field is presented to the analog clock generator on a registered output.

The divide value is staged. Writing the upper-byte register only changes a holding register. Writing the register that carries the low nibble commits the staged upper byte and the new nibble together, in one clock edge, and pulses a commit strobe. Because of this the PLL never sees a half-updated ratio. The divide ratio actually used is the register value plus one, and it is given on a 13-bit output so that the top value cannot wrap.

Top module: `pllcfg_regs`

## Requirements
- R1: After reset the divide value is 1693 (upper byte 0x69, low nibble 0xD), the ratio output is 1694, the VCO band is 01, the post-divider code is 2, the pump code is 001, the phase is 16, the commit strobe is low and read data is 0x00.
- R2: A read of address 0x00 returns the revision parameter (default 0xA5). A write to 0x00 changes nothing.
- R3: A write to address 0x01 stores the byte in the staging register, and a later read of 0x01 returns it. div_val_o does not change.
- R4: A write to address 0x02 sets div_val_o to {staged byte, wdata_i[7:4]}. The new value is visible in the cycle after the write edge.
- R5: div_commit_o is high for exactly the one cycle after each write to 0x02 and low at all other times.
- R6: div_ratio_o always equals div_val_o + 1 as a 13-bit value, so 4095 gives 4096.
- R7: Address 0x03 bits 7..6 hold the VCO band. post_div_o is 3 minus the band (band 00 gives 3, band 11 gives 0) and follows it in the same cycle.
- R8: Address 0x03 bits 5..3 hold the charge-pump current code on cp_cur_o.
- R9: Address 0x04 bits 7..3 hold the phase step on phase_o.
- R10: Bits 3..0 of 0x02 and bits 2..0 of 0x03 and 0x04 read as zero and ignore writes. Writes to unmapped addresses have no effect, and reads of them return zero.
- R11: rdata_o loads the addressed register as it stood before the edge at which re_i is sampled high, and holds its value while re_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| div_val_o | output | 12 | Live feedback divide register value |
| div_ratio_o | output | 13 | Effective divide ratio, value plus one |
| div_commit_o | output | 1 | One-cycle pulse on each divide commit |
| vco_band_o | output | 2 | VCO band select |
| post_div_o | output | 2 | Log2 of the post-divider, derived from the band |
| cp_cur_o | output | 3 | Charge-pump current code |
| phase_o | output | 5 | Sampling phase step |

## Verification
The assertions assume that we_i, re_i and addr_i are known at every sampled edge and that one address is handled per cycle. The commit checks relate the strobe and the nibble to the write seen one edge earlier, so they rely on a single write strobe with no overlap. The directed stimulus changes inputs only on falling edges, gives each write a single strobe cycle, and keeps read and write strobes in separate cycles except where the read-before-write ordering is being tested.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
  localparam int AW = 8;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_REV  = 8'h00;
  localparam logic [AW-1:0] A_DIVH = 8'h01;
  localparam logic [AW-1:0] A_DIVL = 8'h02;
  localparam logic [AW-1:0] A_CLK  = 8'h03;
  localparam logic [AW-1:0] A_PHS  = 8'h04;

  localparam int DIV_HI_W = 8;
  localparam int DIV_LO_W = 4;
  localparam int DIV_W    = DIV_HI_W + DIV_LO_W;
  localparam int DIV_RST  = 1693;

  localparam int VCO_W = 2, VCO_LSB = 6, VCO_RST = 1;
  localparam int CP_W  = 3, CP_LSB  = 3, CP_RST  = 1;
  localparam int PH_W  = 5, PH_LSB  = 3, PH_RST  = 16;
endpackage

// File: rtl/pllcfg_field.sv
module pllcfg_field #(
  parameter int DW  = 8,
  parameter int W   = 2,
  parameter int LSB = 0,
  parameter int RST = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= W'(RST);
    else if (we_i) q_o <= wdata_i[LSB +: W];
  end
endmodule

// File: rtl/pllcfg_div_stage.sv
module pllcfg_div_stage #(
  parameter int DW   = 8,
  parameter int HI_W = 8,
  parameter int LO_W = 4,
  parameter int RST  = 1693,
  localparam int W   = HI_W + LO_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hi_we_i,
  input  logic          lo_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [HI_W-1:0] staged_hi_o,
  output logic [W-1:0]    div_val_o,
  output logic [W:0]      div_ratio_o,
  output logic            commit_o
);
  localparam logic [W-1:0] RST_V = W'(RST);

  logic [W-1:0] next_val;
  assign next_val = {staged_hi_o, wdata_i[DW-1 -: LO_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_hi_o <= RST_V[W-1 -: HI_W];
      div_val_o   <= RST_V;
      div_ratio_o <= {1'b0, RST_V} + 1'b1;
      commit_o    <= 1'b0;
    end else begin
      commit_o <= lo_we_i;
      if (hi_we_i) staged_hi_o <= wdata_i[HI_W-1:0];
      if (lo_we_i) begin
        // upper byte and nibble land in the same edge
        div_val_o   <= next_val;
        div_ratio_o <= {1'b0, next_val} + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pllcfg_rd_port.sv
module pllcfg_rd_port #(
  parameter int DW = 8,
  parameter int N  = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 re_i,
  input  logic [N-1:0]         sel_i,
  input  logic [N-1:0][DW-1:0] src_i,
  output logic [DW-1:0]        rdata_o
);
  logic [DW-1:0] mux;

  always_comb begin
    mux = '0;
    for (int k = 0; k < N; k++)
      if (sel_i[k]) mux = mux | src_i[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mux;
  end
endmodule

// File: rtl/pllcfg_regs.sv
module pllcfg_regs
  import pllcfg_pkg::*;
#(
  parameter logic [DW-1:0] REVISION = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DIV_W-1:0]  div_val_o,
  output logic [DIV_W:0]    div_ratio_o,
  output logic              div_commit_o,
  output logic [VCO_W-1:0]  vco_band_o,
  output logic [1:0]        post_div_o,
  output logic [CP_W-1:0]   cp_cur_o,
  output logic [PH_W-1:0]   phase_o
);
  localparam int NREG = 5;
  localparam logic [AW-1:0] ADDRS [NREG] = '{A_REV, A_DIVH, A_DIVL, A_CLK, A_PHS};

  logic [NREG-1:0] sel;
  logic [NREG-1:0] wsel;
  logic [DIV_HI_W-1:0] staged_hi;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign sel[g]  = (addr_i == ADDRS[g]);
    assign wsel[g] = we_i & sel[g];
  end

  pllcfg_div_stage #(
    .DW(DW), .HI_W(DIV_HI_W), .LO_W(DIV_LO_W), .RST(DIV_RST)
  ) i_div (
    .clk_i, .rst_ni,
    .hi_we_i     (wsel[1]),
    .lo_we_i     (wsel[2]),
    .wdata_i,
    .staged_hi_o (staged_hi),
    .div_val_o,
    .div_ratio_o,
    .commit_o    (div_commit_o)
  );

  pllcfg_field #(.DW(DW), .W(VCO_W), .LSB(VCO_LSB), .RST(VCO_RST)) i_vco (
    .clk_i, .rst_ni, .we_i(wsel[3]), .wdata_i, .q_o(vco_band_o));
  pllcfg_field #(.DW(DW), .W(CP_W), .LSB(CP_LSB), .RST(CP_RST)) i_cp (
    .clk_i, .rst_ni, .we_i(wsel[3]), .wdata_i, .q_o(cp_cur_o));
  pllcfg_field #(.DW(DW), .W(PH_W), .LSB(PH_LSB), .RST(PH_RST)) i_ph (
    .clk_i, .rst_ni, .we_i(wsel[4]), .wdata_i, .q_o(phase_o));

  // post-divider log2 follows the band: low band divides most
  logic [VCO_W-1:0] band_inv;
  assign band_inv = ~wdata_i[VCO_LSB +: VCO_W];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      post_div_o <= 2'(3 - VCO_RST);
    else if (wsel[3]) post_div_o <= band_inv;
  end

  logic [NREG-1:0][DW-1:0] src;
  assign src[0] = REVISION;
  assign src[1] = staged_hi;
  assign src[2] = {div_val_o[DIV_LO_W-1:0], {(DW-DIV_LO_W){1'b0}}};
  assign src[3] = {vco_band_o, cp_cur_o, {(DW-VCO_W-CP_W){1'b0}}};
  assign src[4] = {phase_o, {(DW-PH_W){1'b0}}};

  pllcfg_rd_port #(.DW(DW), .N(NREG)) i_rd (
    .clk_i, .rst_ni, .re_i, .sel_i(sel), .src_i(src), .rdata_o);
endmodule

// File: rtl/pllcfg_regs_chk.sv
module pllcfg_regs_chk
  import pllcfg_pkg::*;
#(
  parameter logic [DW-1:0] REVISION = 8'hA5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              we_i,
  input logic              re_i,
  input logic [DW-1:0]     rdata_o,
  input logic [DIV_W-1:0]  div_val_o,
  input logic [DIV_W:0]    div_ratio_o,
  input logic              div_commit_o,
  input logic [VCO_W-1:0]  vco_band_o,
  input logic [1:0]        post_div_o,
  input logic [CP_W-1:0]   cp_cur_o,
  input logic [PH_W-1:0]   phase_o
);
  a_r3_stage_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIVH) |=> $stable(div_val_o));

  a_r4_hold_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_DIVL) |=> $stable(div_val_o));

  a_r4_nibble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIVL) |=> div_val_o[3:0] == $past(wdata_i[7:4]));

  a_r5_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIVL) |=> div_commit_o);

  a_r5_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_DIVL) |=> !div_commit_o);

  a_r6_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_ratio_o == {1'b0, div_val_o} + 13'd1);

  a_r7_post_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_div_o == 2'd3 - vco_band_o);

  a_r2_revision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_REV) |=> rdata_o == REVISION);

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  a_r10_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (addr_i == A_CLK || addr_i == A_PHS)) |=> rdata_o[2:0] == 3'b000);
endmodule

bind pllcfg_regs pllcfg_regs_chk #(.REVISION(REVISION)) i_pllcfg_regs_chk (.*);

// File: tb/test_pllcfg_regs.sv
module test_pllcfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [7:0]  rdata;
  logic [11:0] div_val;
  logic [12:0] div_ratio;
  logic        commit;
  logic [1:0]  vco_band;
  logic [1:0]  post_div;
  logic [2:0]  cp_cur;
  logic [4:0]  phase;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pllcfg_regs i_pllcfg_regs (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .div_val_o(div_val),
    .div_ratio_o(div_ratio), .div_commit_o(commit), .vco_band_o(vco_band),
    .post_div_o(post_div), .cp_cur_o(cp_cur), .phase_o(phase));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic t_reset;
    chk("R1 div", div_val, 1693);
    chk("R1 ratio", div_ratio, 1694);
    chk("R1 band", vco_band, 1);
    chk("R1 post", post_div, 2);
    chk("R1 cp", cp_cur, 1);
    chk("R1 phase", phase, 16);
    chk("R1 commit", commit, 0);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_revision;
    logic [7:0] v;
    rd(8'h00, v); chk("R2 read", v, 8'hA5);
    wr(8'h00, 8'h3C);
    rd(8'h00, v); chk("R2 write ignored", v, 8'hA5);
  endtask

  task automatic t_stage_only;
    logic [7:0] v;
    wr(8'h01, 8'h12);
    chk("R3 no commit", commit, 0);
    chk("R3 live held", div_val, 1693);
    rd(8'h01, v); chk("R3 staged readback", v, 8'h12);
    repeat (3) @(negedge clk);
    chk("R3 still held", div_val, 1693);
  endtask

  task automatic t_commit;
    logic [7:0] v;
    wr(8'h02, 8'h7F);
    chk("R4 value", div_val, 12'h127);
    chk("R5 pulse", commit, 1);
    chk("R6 ratio", div_ratio, 12'h127 + 1);
    @(negedge clk);
    chk("R5 single cycle", commit, 0);
    rd(8'h02, v); chk("R10 nibble low bits", v, 8'h70);
    wr(8'h01, 8'h00); wr(8'h02, 8'h20);
    chk("R4 min legal", div_val, 2);
    chk("R6 min ratio", div_ratio, 3);
  endtask

  task automatic t_max;
    wr(8'h01, 8'hFF); wr(8'h02, 8'hF0);
    chk("R4 max", div_val, 4095);
    chk("R6 no overflow", div_ratio, 4096);
  endtask

  task automatic t_fields;
    logic [7:0] v;
    for (int b = 0; b < 4; b++) begin
      wr(8'h03, 8'((b << 6) | (((b + 3) % 8) << 3) | 3'b111));
      chk("R7 band", vco_band, b);
      chk("R7 post div", post_div, 3 - b);
      chk("R8 cp", cp_cur, (b + 3) % 8);
    end
    rd(8'h03, v); chk("R10 clk low bits", v, 8'hF0);
    wr(8'h04, 8'hFF); chk("R9 phase max", phase, 31);
    wr(8'h04, 8'h05); chk("R9 phase zero", phase, 0);
    wr(8'h04, 8'h48); chk("R9 phase 9", phase, 9);
    rd(8'h04, v); chk("R10 phase low bits", v, 8'h48);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(8'h05, 8'h00); wr(8'hFF, 8'h00); wr(8'h81, 8'h00); wr(8'h82, 8'h00);
    chk("R10 div kept", div_val, 4095);
    chk("R10 commit none", commit, 0);
    chk("R10 band kept", vco_band, 3);
    chk("R10 phase kept", phase, 9);
    rd(8'h01, v); chk("R10 staged kept", v, 8'hFF);
    rd(8'h05, v); chk("R10 unmapped read", v, 0);
  endtask

  task automatic t_read_order;
    logic [7:0] v;
    rd(8'h04, v);
    @(negedge clk); addr = 8'h04; wdata = 8'h18; we = 1'b1; re = 1'b1;
    @(negedge clk); we = 1'b0; re = 1'b0;
    chk("R11 pre-write value", rdata, 8'h48);
    chk("R9 written", phase, 3);
    addr = 8'h00;
    repeat (2) @(negedge clk);
    chk("R11 hold", rdata, 8'h48);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_revision();
    t_stage_only();
    t_commit();
    t_max();
    t_fields();
    t_unmapped();
    t_read_order();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule